// File: doc/BRIEF.md
# Failed-Block Pointer Remap Controller

This block sits in front of a phase-change memory built from 512-bit (64-byte) blocks. Every block carries one extra flag bit that marks it as retired. When a block has gathered more hard faults than the error code can correct, software issues a remap request. The controller then writes the spare block's address into the failed block itself, eight copies of it, and sets the flag. All of this happens in one block write.

Later reads and writes to a retired block are redirected. The controller first reads the block. Seeing the flag, it rebuilds the 32-bit redirect address by a per-bit majority vote over the eight copies. It then makes a second access at the spare location. A fully associative eight-entry pointer cache with least-recently-used replacement holds recently decoded redirects. On a hit, the first access is skipped and only the spare block is touched.

The memory port uses a request/acknowledge handshake. Read data and the flag come back with the acknowledge. One host request is in flight at a time, and `req_ready` is high only when the controller is idle.

Top module: `pcm_redirect_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: A read (op code 0) of a block whose flag is 0, with no cached pointer, makes exactly one memory read at the requested address. It then responds with that block's data, `rsp_redirected`=0 and `rsp_cache_hit`=0.
- R3: A remap request (op code 2) makes exactly one memory write at the requested address. The flag is set to 1. Copy k of the spare address goes to bits [32k+31:32k] for k=0..7, and bits [511:256] are zero. A response follows.
- R4: A read of a flagged block whose pointer is not cached makes two memory accesses: a read at the requested address, then a read at the decoded address. It responds with the second block's data, `rsp_redirected`=1 and `rsp_cache_hit`=0.
- R5: Each decoded pointer bit is 1 only when at least 5 of its 8 copies are 1, so a 4-4 tie gives 0 and up to 3 corrupted copies are outvoted. Bits [511:256] of the flagged block have no effect.
- R6: A read or write to an address whose pointer is cached makes one memory access, at the cached address, and responds with `rsp_cache_hit`=1 and `rsp_redirected`=1.
- R7: Every pointer decode fills the cache, so the next access to the same address hits.
- R8: A remap request loads or overwrites the cache entry for its address, so a following access hits and uses the new spare address.
- R9: The cache holds eight pointers. Inserting a new one when full evicts the least recently used entry, and both hits and inserts count as use.
- R10: A write (op code 1) with no cached pointer first reads the requested block. If the flag is 0, it writes `req_wdata` there with flag 0. If the flag is 1, it writes the data with flag 0 to the decoded address and leaves the retired block unchanged.
- R11: While `mem_req` is high and no acknowledge has arrived, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_op | input | 2 | 0 read, 1 write, 2 remap |
| req_addr | input | 32 | Block address of the request |
| req_wdata | input | 512 | Write data for op 1 |
| req_spare | input | 32 | Spare block address for op 2 |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 512 | Read data (meaningful for op 0) |
| rsp_redirected | output | 1 | Request was served at a spare block |
| rsp_cache_hit | output | 1 | Pointer came from the cache |
| mem_req | output | 1 | Memory access request, held until acknowledge |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Memory block address |
| mem_wdata | output | 512 | Memory write data |
| mem_wflag | output | 1 | Retired flag written with the block |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | 512 | Block read data |
| mem_rflag | input | 1 | Retired flag read with the block |

## Verification
The bench's memory model acknowledges two cycles after it first sees `mem_req`, which makes every memory access cost exactly three clock edges. The pointer decode adds one more edge. Counted from the edge that accepts a request, the response is due after 3 edges for a plain read, a remap or a cache hit; after 6 for a write to a healthy block; and after 7 for any access that decodes a pointer. Each task counts edges until `rsp_valid` is seen at a falling edge and compares that count with this formula. It also checks the number of acknowledged accesses and the memory contents left behind.

// File: rtl/pcm_remap_pkg.sv
package pcm_remap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_DECODE,
        ST_SECOND,
        ST_RESPOND
    } ctrl_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_REMAP = 2'd2,
        OP_RSVD  = 2'd3
    } req_op_e;

    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_BLK_W   = 512;
    localparam int unsigned DEF_N_COPY  = 8;
    localparam int unsigned DEF_ENTRIES = 8;

endpackage

// File: rtl/pcm_ptr_replicate.sv
module pcm_ptr_replicate #(
    parameter int unsigned ADDR_W = pcm_remap_pkg::DEF_ADDR_W,
    parameter int unsigned N_COPY = pcm_remap_pkg::DEF_N_COPY,
    localparam int unsigned FIELD_W = ADDR_W * N_COPY
) (
    input  logic [ADDR_W-1:0]  ptr_in,
    output logic [FIELD_W-1:0] field_out
);
    // Copy k of the pointer lands in slot k of the field.
    for (genvar k = 0; k < N_COPY; k++) begin : g_copy
        assign field_out[k*ADDR_W +: ADDR_W] = ptr_in;
    end
endmodule

// File: rtl/pcm_ptr_vote.sv
module pcm_ptr_vote #(
    parameter int unsigned ADDR_W = pcm_remap_pkg::DEF_ADDR_W,
    parameter int unsigned N_COPY = pcm_remap_pkg::DEF_N_COPY,
    localparam int unsigned FIELD_W  = ADDR_W * N_COPY,
    localparam int unsigned CNT_W    = $clog2(N_COPY + 1),
    localparam int unsigned VOTE_MIN = N_COPY / 2 + 1
) (
    input  logic [FIELD_W-1:0] field_in,
    output logic [ADDR_W-1:0]  ptr_out
);
    // A bit is set only on a strict majority; a tie resolves to zero.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        logic [CNT_W-1:0] ones;
        always_comb begin
            ones = '0;
            for (int k = 0; k < N_COPY; k++) begin
                ones = ones + CNT_W'(field_in[k*ADDR_W + b]);
            end
        end
        assign ptr_out[b] = (ones >= CNT_W'(VOTE_MIN));
    end
endmodule

// File: rtl/pcm_ptr_cache.sv
module pcm_ptr_cache #(
    parameter int unsigned ADDR_W  = pcm_remap_pkg::DEF_ADDR_W,
    parameter int unsigned ENTRIES = pcm_remap_pkg::DEF_ENTRIES,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_ptr,
    input  logic              touch_en,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [ADDR_W-1:0] upd_ptr
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] tag;
        logic [ADDR_W-1:0] ptr;
        logic [IDX_W-1:0]  age;
    } ent_t;

    ent_t [ENTRIES-1:0] ent_d, ent_q;

    logic [ENTRIES-1:0] lk_vec, up_vec, free_vec, old_vec;
    logic [IDX_W-1:0]   lk_idx, up_idx, free_idx, old_idx;
    logic [IDX_W-1:0]   victim, sel, ref_age;
    logic               do_touch;

    // Match vectors and the lowest-numbered index of each class
    always_comb begin
        lk_vec   = '0;
        up_vec   = '0;
        free_vec = '0;
        old_vec  = '0;
        lk_idx   = '0;
        up_idx   = '0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_vec[i]   = ent_q[i].vld && (ent_q[i].tag == lk_addr);
            up_vec[i]   = ent_q[i].vld && (ent_q[i].tag == upd_addr);
            free_vec[i] = !ent_q[i].vld;
            old_vec[i]  = (ent_q[i].age == IDX_W'(ENTRIES - 1));
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_vec[i])   lk_idx   = IDX_W'(i);
            if (up_vec[i])   up_idx   = IDX_W'(i);
            if (free_vec[i]) free_idx = IDX_W'(i);
            if (old_vec[i])  old_idx  = IDX_W'(i);
        end
    end

    assign lk_hit = |lk_vec;
    assign lk_ptr = ent_q[lk_idx].ptr;

    // Next state: insert/overwrite, then age update (ages stay a permutation)
    always_comb begin
        ent_d    = ent_q;
        victim   = (|up_vec) ? up_idx : ((|free_vec) ? free_idx : old_idx);
        sel      = upd_en ? victim : lk_idx;
        do_touch = upd_en || (touch_en && lk_hit);
        ref_age  = ent_q[sel].age;
        if (upd_en) begin
            ent_d[victim].vld = 1'b1;
            ent_d[victim].tag = upd_addr;
            ent_d[victim].ptr = upd_ptr;
        end
        if (do_touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == sel) begin
                    ent_d[i].age = '0;
                end else if (ent_q[i].age < ref_age) begin
                    ent_d[i].age = ent_q[i].age + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i].vld <= 1'b0;
                ent_q[i].tag <= '0;
                ent_q[i].ptr <= '0;
                ent_q[i].age <= IDX_W'(i);
            end
        end else begin
            ent_q <= ent_d;
        end
    end

    // R8
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec) && $onehot0(up_vec));

    // R9
    lru_single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(old_vec) == 1);

    // R9
    lru_touch_youngest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && lk_hit && !upd_en) |=> ($countones(old_vec) == 1) && !$stable(ent_q) || $past(ent_q[lk_idx].age) == '0);
endmodule

// File: rtl/pcm_redirect_ctrl.sv
module pcm_redirect_ctrl
    import pcm_remap_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned BLK_W   = DEF_BLK_W,
    parameter int unsigned N_COPY  = DEF_N_COPY,
    parameter int unsigned ENTRIES = DEF_ENTRIES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BLK_W-1:0]  req_wdata,
    input  logic [ADDR_W-1:0] req_spare,
    output logic              rsp_valid,
    output logic [BLK_W-1:0]  rsp_rdata,
    output logic              rsp_redirected,
    output logic              rsp_cache_hit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    output logic              mem_wflag,
    input  logic              mem_ack,
    input  logic [BLK_W-1:0]  mem_rdata,
    input  logic              mem_rflag
);
    localparam int unsigned FIELD_W = ADDR_W * N_COPY;

    typedef struct packed {
        ctrl_state_e       st;
        req_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] spare;
        logic [ADDR_W-1:0] target;
        logic [BLK_W-1:0]  data;
        logic [BLK_W-1:0]  wdata;
        logic              redir;
        logic              hit;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [FIELD_W-1:0] rep_field;
    logic [ADDR_W-1:0]  vote_ptr;
    logic               lk_hit, touch_en, upd_en;
    logic [ADDR_W-1:0]  lk_ptr, upd_addr, upd_ptr;

    pcm_ptr_replicate #(.ADDR_W(ADDR_W), .N_COPY(N_COPY)) rep_i (
        .ptr_in    (ctrl_q.spare),
        .field_out (rep_field)
    );

    pcm_ptr_vote #(.ADDR_W(ADDR_W), .N_COPY(N_COPY)) vote_i (
        .field_in (ctrl_q.data[FIELD_W-1:0]),
        .ptr_out  (vote_ptr)
    );

    pcm_ptr_cache #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) cache_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_addr  (req_addr),
        .lk_hit   (lk_hit),
        .lk_ptr   (lk_ptr),
        .touch_en (touch_en),
        .upd_en   (upd_en),
        .upd_addr (upd_addr),
        .upd_ptr  (upd_ptr)
    );

    always_comb begin
        ctrl_d    = ctrl_q;
        touch_en  = 1'b0;
        upd_en    = 1'b0;
        upd_addr  = ctrl_q.addr;
        upd_ptr   = vote_ptr;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ctrl_q.addr;
        mem_wdata = ctrl_q.wdata;
        mem_wflag = 1'b0;
        rsp_valid = 1'b0;

        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.op    = req_op_e'(req_op);
                    ctrl_d.addr  = req_addr;
                    ctrl_d.spare = req_spare;
                    ctrl_d.wdata = req_wdata;
                    ctrl_d.redir = 1'b0;
                    ctrl_d.hit   = 1'b0;
                    if (req_op_e'(req_op) == OP_REMAP) begin
                        ctrl_d.st = ST_FIRST;
                    end else if (lk_hit) begin
                        touch_en      = 1'b1;
                        ctrl_d.target = lk_ptr;
                        ctrl_d.redir  = 1'b1;
                        ctrl_d.hit    = 1'b1;
                        ctrl_d.st     = ST_SECOND;
                    end else begin
                        ctrl_d.st = ST_FIRST;
                    end
                end
            end
            ST_FIRST: begin
                mem_req  = 1'b1;
                mem_addr = ctrl_q.addr;
                if (ctrl_q.op == OP_REMAP) begin
                    mem_we    = 1'b1;
                    mem_wdata = BLK_W'(rep_field);
                    mem_wflag = 1'b1;
                end
                if (mem_ack) begin
                    if (ctrl_q.op == OP_REMAP) begin
                        upd_en    = 1'b1;
                        upd_ptr   = ctrl_q.spare;
                        ctrl_d.st = ST_RESPOND;
                    end else if (mem_rflag) begin
                        ctrl_d.data = mem_rdata;
                        ctrl_d.st   = ST_DECODE;
                    end else if (ctrl_q.op == OP_WRITE) begin
                        ctrl_d.target = ctrl_q.addr;
                        ctrl_d.st     = ST_SECOND;
                    end else begin
                        ctrl_d.data = mem_rdata;
                        ctrl_d.st   = ST_RESPOND;
                    end
                end
            end
            ST_DECODE: begin
                upd_en        = 1'b1;
                ctrl_d.target = vote_ptr;
                ctrl_d.redir  = 1'b1;
                ctrl_d.st     = ST_SECOND;
            end
            ST_SECOND: begin
                mem_req   = 1'b1;
                mem_addr  = ctrl_q.target;
                mem_we    = (ctrl_q.op == OP_WRITE);
                mem_wdata = ctrl_q.wdata;
                if (mem_ack) begin
                    if (ctrl_q.op != OP_WRITE) begin
                        ctrl_d.data = mem_rdata;
                    end
                    ctrl_d.st = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                rsp_valid = 1'b1;
                ctrl_d.st = ST_IDLE;
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_ready      = (ctrl_q.st == ST_IDLE);
    assign rsp_rdata      = ctrl_q.data;
    assign rsp_redirected = ctrl_q.redir;
    assign rsp_cache_hit  = ctrl_q.hit;

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R3
    remap_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_wflag) |-> mem_wdata[ADDR_W-1:0] == mem_wdata[FIELD_W-1 -: ADDR_W]);

    // R6
    hit_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cache_hit) |-> rsp_redirected);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/pcm_redirect_ctrl_tb_top.sv
module pcm_redirect_ctrl_tb_top;
    localparam int AW  = 32;
    localparam int BW  = 512;
    localparam int LAT = 2;
    localparam int NB  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_wdata = '0;
    logic [AW-1:0] req_spare = '0;
    logic          rsp_valid;
    logic [BW-1:0] rsp_rdata;
    logic          rsp_redirected, rsp_cache_hit;
    logic          mem_req, mem_we, mem_wflag;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [BW-1:0] mem_rdata = '0;
    logic          mem_rflag = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int n_acc = 0;
    int hold_err = 0;
    int cnt = 0;
    logic [AW-1:0] start_addr = '0;
    logic [BW-1:0] blk_mem [NB];
    logic          flg_mem [NB];

    always #4 clk = ~clk;

    pcm_redirect_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_spare(req_spare),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_redirected(rsp_redirected), .rsp_cache_hit(rsp_cache_hit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wflag(mem_wflag),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_rflag(mem_rflag)
    );

    // Memory model: acknowledge LAT cycles after a request is first seen
    always @(posedge clk) begin
        if (!rst_n || mem_ack) begin
            mem_ack <= 1'b0;
            cnt     <= 0;
        end else if (mem_req) begin
            if (cnt == 0) start_addr <= mem_addr;
            else if (mem_addr != start_addr) hold_err <= hold_err + 1;
            if (cnt == LAT - 1) begin
                mem_ack <= 1'b1;
                n_acc   <= n_acc + 1;
                cnt     <= 0;
                if (mem_we) begin
                    blk_mem[mem_addr[5:0]] <= mem_wdata;
                    flg_mem[mem_addr[5:0]] <= mem_wflag;
                end else begin
                    mem_rdata <= blk_mem[mem_addr[5:0]];
                    mem_rflag <= flg_mem[mem_addr[5:0]];
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    function automatic logic [BW-1:0] pat(input int i);
        return {16{32'hD000_0000 | 32'(i)}};
    endfunction

    function automatic logic [BW-1:0] ptr_blk(input logic [AW-1:0] p);
        return {256'h0, {8{p}}};
    endfunction

    task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [BW-1:0] r_data;
    logic          r_redir, r_hit;
    int            r_acc, r_cyc;

    task automatic do_req(input logic [1:0] op, input int addr, input logic [BW-1:0] wd, input int spare);
        int a0;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = AW'(addr);
        req_wdata = wd;
        req_spare = AW'(spare);
        a0 = n_acc;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_cyc = 0;
        while (!rsp_valid && r_cyc < 100) begin
            @(posedge clk);
            r_cyc++;
            @(negedge clk);
        end
        r_data  = rsp_rdata;
        r_redir = rsp_redirected;
        r_hit   = rsp_cache_hit;
        r_acc   = n_acc - a0;
    endtask

    task automatic t_reset();
        check("R1 ready", BW'(req_ready), 1);
        check("R1 rsp_valid", BW'(rsp_valid), 0);
        check("R1 mem_req", BW'(mem_req), 0);
    endtask

    task automatic t_plain_read();
        do_req(2'd0, 2, '0, 0);
        check("R2 data", r_data, pat(2));
        check("R2 redir", BW'(r_redir), 0);
        check("R2 hit", BW'(r_hit), 0);
        check("R2 accesses", BW'(r_acc), 1);
        check("R2 latency", BW'(r_cyc), LAT + 1);
    endtask

    task automatic t_remap();
        do_req(2'd2, 3, '0, 9);
        check("R3 block", blk_mem[3], ptr_blk(9));
        check("R3 flag", BW'(flg_mem[3]), 1);
        check("R3 accesses", BW'(r_acc), 1);
        check("R3 latency", BW'(r_cyc), LAT + 1);
        do_req(2'd0, 3, '0, 0);
        check("R6 R8 data", r_data, pat(9));
        check("R6 hit", BW'(r_hit), 1);
        check("R6 redir", BW'(r_redir), 1);
        check("R6 accesses", BW'(r_acc), 1);
        check("R6 latency", BW'(r_cyc), LAT + 1);
    endtask

    task automatic t_vote();
        logic [BW-1:0] b;
        b = ptr_blk(10);
        b[BW-1:256] = {8{32'hFFFF_FFFF}};
        for (int k = 0; k < 3; k++) b[k*32 +: 32] = 32'hFFFF_FFF5;
        blk_mem[5] = b;
        flg_mem[5] = 1'b1;
        do_req(2'd0, 5, '0, 0);
        check("R4 R5 data", r_data, pat(10));
        check("R4 redir", BW'(r_redir), 1);
        check("R4 hit", BW'(r_hit), 0);
        check("R4 accesses", BW'(r_acc), 2);
        check("R4 latency", BW'(r_cyc), 2 * (LAT + 1) + 1);
        b = ptr_blk(32'hB);
        for (int k = 4; k < 8; k++) b[k*32 +: 32] = 32'hF;
        blk_mem[6] = b;
        flg_mem[6] = 1'b1;
        do_req(2'd0, 6, '0, 0);
        check("R5 tie data", r_data, pat(11));
        do_req(2'd0, 5, '0, 0);
        check("R7 hit", BW'(r_hit), 1);
        check("R7 accesses", BW'(r_acc), 1);
        check("R7 data", r_data, pat(10));
    endtask

    task automatic t_write();
        logic [BW-1:0] w1, w2;
        w1 = {16{32'h1234_5678}};
        w2 = {16{32'hCAFE_0007}};
        do_req(2'd1, 1, w1, 0);
        check("R10 plain block", blk_mem[1], w1);
        check("R10 plain flag", BW'(flg_mem[1]), 0);
        check("R10 plain accesses", BW'(r_acc), 2);
        check("R10 plain latency", BW'(r_cyc), 2 * (LAT + 1));
        blk_mem[7] = ptr_blk(12);
        flg_mem[7] = 1'b1;
        do_req(2'd1, 7, w2, 0);
        check("R10 spare block", blk_mem[12], w2);
        check("R10 spare flag", BW'(flg_mem[12]), 0);
        check("R10 retired kept", blk_mem[7], ptr_blk(12));
        check("R10 retired flag", BW'(flg_mem[7]), 1);
        check("R10 redirect latency", BW'(r_cyc), 2 * (LAT + 1) + 1);
    endtask

    task automatic t_remap_update();
        do_req(2'd2, 5, '0, 13);
        do_req(2'd0, 5, '0, 0);
        check("R8 update hit", BW'(r_hit), 1);
        check("R8 update data", r_data, pat(13));
    endtask

    task automatic t_lru();
        for (int i = 0; i < 8; i++) do_req(2'd2, 40 + i, '0, 20 + i);
        do_req(2'd0, 40, '0, 0);
        check("R9 touched hit", BW'(r_hit), 1);
        do_req(2'd2, 48, '0, 28);
        do_req(2'd0, 41, '0, 0);
        check("R9 evicted miss", BW'(r_hit), 0);
        check("R9 evicted accesses", BW'(r_acc), 2);
        check("R9 evicted data", r_data, pat(21));
        do_req(2'd0, 40, '0, 0);
        check("R9 kept 40", BW'(r_hit), 1);
        do_req(2'd0, 43, '0, 0);
        check("R9 kept 43", BW'(r_hit), 1);
        check("R9 kept data", r_data, pat(23));
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < NB; i++) begin
            blk_mem[i] = pat(i);
            flg_mem[i] = 1'b0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_read();
        t_remap();
        t_vote();
        t_write();
        t_remap_update();
        t_lru();
        check("R11 request hold", BW'(hold_err), 0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule